// File: doc/BRIEF.md
# Tagged Receive Queue for a Serial Port

This block is the receive-side character queue of a 16550-class serial port. Completed characters from the receive deserialiser enter a sixteen-slot queue. Each character carries three tags: parity error, framing error and break. A CPU read of the receive buffer removes the oldest character. A write to the queue control register turns queueing on or off, empties the queue and picks the threshold at which the receive interrupt source becomes active.

The tags are not reported when a character is stored. They reach the status outputs only when their character becomes the oldest entry. At that moment they are OR-ed into sticky head-error flags, and a status-register read clears those flags. A separate summary output stays high while any stored character carries a tag. When the queue has no room, the incoming character is dropped, the stored characters are kept, and a sticky overrun flag is raised. With queueing off, the block acts as a one-character holding register.

Top module: `rxq_top`

## Requirements
- R1: After reset the queue is empty, queueing is off with threshold code 00, and dataReady, overrun, trigHit, errInQueue and all three head-error outputs are 0.
- R2: Characters leave in arrival order. rdData shows the oldest character and is 0 when the queue is empty. dataReady is 1 exactly while the queue holds at least one character.
- R3: With queueing on, the queue holds 16 characters. A character that arrives while the queue is full is dropped, overrun goes to 1, and the stored characters stay unchanged.
- R4: overrun stays 1 until a status read (statusRead) and is 0 in the cycle after that read, unless another character is dropped in the same cycle.
- R5: Control bit 0 (ctlData[0]) turns queueing on. With queueing off, the capacity is one character, and a second arrival before a read is an overrun.
- R6: A control write with bit 0 clear turns queueing off but ignores bits 1 and 7:6. Stored characters and the threshold code are kept.
- R7: A control write with bits 0 and 1 both set empties the queue in one cycle and drops any character arriving in that cycle. The clear request is not stored, so later writes with bit 1 clear do not empty the queue.
- R8: Control bits 7:6, written together with bit 0, set the threshold: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14 characters. trigHit is 1 while the number of stored characters is at least the threshold. With queueing off, the threshold is 1.
- R9: When a character becomes the oldest entry, its parity, framing and break tags are OR-ed into headParErr, headFrmErr and headBrk. Those flags stay set until a status read clears them.
- R10: errInQueue is 1 while any stored character carries at least one tag.
- R11: A character that arrives with the break tag set is stored as data 0x00, whatever its data input.
- R12: A buffer read (popReq) while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | A completed character is offered this cycle |
| pushData | input | 8 | Character data |
| pushParErr | input | 1 | Parity error tag of the offered character |
| pushFrmErr | input | 1 | Framing error tag of the offered character |
| pushBrk | input | 1 | Break tag of the offered character |
| popReq | input | 1 | CPU read of the receive buffer (removes the oldest character) |
| statusRead | input | 1 | CPU read of the status register |
| ctlWrite | input | 1 | Queue control register write strobe |
| ctlData | input | 8 | Control value: bit0 enable, bit1 clear, bits7:6 threshold |
| rdData | output | 8 | Oldest stored character |
| dataReady | output | 1 | Queue is not empty |
| overrun | output | 1 | Sticky dropped-character flag |
| trigHit | output | 1 | Stored characters have reached the threshold |
| headParErr | output | 1 | Sticky parity flag of the oldest character |
| headFrmErr | output | 1 | Sticky framing flag of the oldest character |
| headBrk | output | 1 | Sticky break flag of the oldest character |
| errInQueue | output | 1 | At least one stored character carries a tag |

## Verification
A wrong read pointer shows on rdData at the very next buffer read, as a character out of arrival order. A wrong occupancy count shows first at the capacity edge: overrun rises one character early or late. The same fault also shows at the threshold edges, where trigHit changes one push off from the expected count. A tag stored in the wrong slot shows at the head-error outputs in the cycle after its neighbour becomes the head, and errInQueue falls one pop early or late.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int RXQ_DW = 8;

  typedef struct packed {
    logic parErr;
    logic frmErr;
    logic brk;
  } rxqTags_t;

  typedef struct packed {
    logic [RXQ_DW-1:0] data;
    rxqTags_t          tags;
  } rxqEntry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic push;          // write incoming entry at tail
    logic pop;           // advance head
    logic clear;         // reset pointers
    logic headLoad;      // a new entry becomes head this cycle
    logic headFromPush;  // that new head is the incoming entry
    logic latchClr;      // status read clears sticky head flags
  } rxqStrobes_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pushValid,
  input  logic          popReq,
  input  logic          statusRead,
  input  logic          ctlWrite,
  input  logic [7:0]    ctlData,
  output rxqStrobes_t   strb,
  output logic [CW-1:0] count,
  output logic          dataReady,
  output logic          overrun,
  output logic          trigHit
);
  localparam logic [CW-1:0] LVL0 = CW'(1);
  localparam logic [CW-1:0] LVL1 = CW'(DEPTH / 4);
  localparam logic [CW-1:0] LVL2 = CW'(DEPTH / 2);
  localparam logic [CW-1:0] LVL3 = CW'(DEPTH - 2);

  logic          fifoEn;
  logic [1:0]    trigSel;
  logic [CW-1:0] cap;
  logic [CW-1:0] level;
  logic          clearNow, popOk, room, pushOk, dropNow;

  always_comb begin
    cap      = fifoEn ? CW'(DEPTH) : CW'(1);
    clearNow = ctlWrite && ctlData[0] && ctlData[1];
    popOk    = popReq && (count != '0) && !clearNow;
    room     = (count < cap) || popOk;
    pushOk   = pushValid && room && !clearNow;
    dropNow  = pushValid && !room && !clearNow;
  end

  always_comb begin
    strb              = '0;
    strb.push         = pushOk;
    strb.pop          = popOk;
    strb.clear        = clearNow;
    strb.latchClr     = statusRead;
    if (pushOk && ((count == '0) || ((count == CW'(1)) && popOk))) begin
      strb.headLoad     = 1'b1;
      strb.headFromPush = 1'b1;
    end else if (popOk && (count >= CW'(2))) begin
      strb.headLoad     = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoEn  <= 1'b0;
      trigSel <= 2'b00;
    end else if (ctlWrite) begin
      fifoEn <= ctlData[0];
      if (ctlData[0]) trigSel <= ctlData[7:6];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         count <= '0;
    else if (clearNow) count <= '0;
    else               count <= count + CW'(pushOk) - CW'(popOk);
  end

  always_ff @(posedge clk) begin
    if (!rstN)           overrun <= 1'b0;
    else if (dropNow)    overrun <= 1'b1;
    else if (statusRead) overrun <= 1'b0;
  end

  always_comb begin
    unique case (fifoEn ? trigSel : 2'b00)
      2'b00:   level = LVL0;
      2'b01:   level = LVL1;
      2'b10:   level = LVL2;
      default: level = LVL3;
    endcase
    trigHit   = count >= level;
    dataReady = count != '0;
  end
endmodule

// File: rtl/rxq_data.sv
module rxq_data
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxqStrobes_t       strb,
  input  logic [CW-1:0]     count,
  input  logic [RXQ_DW-1:0] pushData,
  input  rxqTags_t          pushTags,
  output logic [RXQ_DW-1:0] rdData,
  output rxqTags_t          headFlags,
  output logic              errInQueue
);
  rxqEntry_t   mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr, rdNext;
  rxqEntry_t   inEntry;
  logic [DEPTH-1:0] slotErr;

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    rdNext       = advance(rdPtr);
    inEntry.tags = pushTags;
    inEntry.data = pushTags.brk ? '0 : pushData;
  end

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= inEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= advance(wrPtr);
      if (strb.pop)  rdPtr <= rdNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headFlags <= '0;
    end else if (strb.headLoad) begin
      headFlags <= (strb.latchClr ? rxqTags_t'('0) : headFlags)
                 | (strb.headFromPush ? pushTags : mem[rdNext].tags);
    end else if (strb.latchClr) begin
      headFlags <= '0;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_comb begin
      automatic int off = i - int'(rdPtr);
      if (off < 0) off = off + DEPTH;
      slotErr[i] = (off < int'(count)) && (|mem[i].tags);
    end
  end

  always_comb begin
    errInQueue = |slotErr;
    rdData     = (count != '0) ? mem[rdPtr].data : '0;
  end
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pushValid,
  input  logic [7:0] pushData,
  input  logic       pushParErr,
  input  logic       pushFrmErr,
  input  logic       pushBrk,
  input  logic       popReq,
  input  logic       statusRead,
  input  logic       ctlWrite,
  input  logic [7:0] ctlData,
  output logic [7:0] rdData,
  output logic       dataReady,
  output logic       overrun,
  output logic       trigHit,
  output logic       headParErr,
  output logic       headFrmErr,
  output logic       headBrk,
  output logic       errInQueue
);
  localparam int CW = $clog2(DEPTH + 1);

  rxqStrobes_t   strb;
  logic [CW-1:0] count;
  rxqTags_t      pushTags, headFlags;

  always_comb begin
    pushTags.parErr = pushParErr;
    pushTags.frmErr = pushFrmErr;
    pushTags.brk    = pushBrk;
    headParErr      = headFlags.parErr;
    headFrmErr      = headFlags.frmErr;
    headBrk         = headFlags.brk;
  end

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .popReq(popReq),
    .statusRead(statusRead), .ctlWrite(ctlWrite), .ctlData(ctlData),
    .strb(strb), .count(count), .dataReady(dataReady),
    .overrun(overrun), .trigHit(trigHit)
  );

  rxq_data #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .count(count),
    .pushData(pushData), .pushTags(pushTags), .rdData(rdData),
    .headFlags(headFlags), .errInQueue(errInQueue)
  );
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          pushValid,
  input logic          pushBrk,
  input logic          popReq,
  input logic          ctlWrite,
  input logic [7:0]    ctlData,
  input logic          statusRead,
  input logic [CW-1:0] count,
  input rxqStrobes_t   strb,
  input logic [7:0]    rdData,
  input logic          dataReady,
  input logic          overrun,
  input logic          headBrk
);
  assert_pop_shrinks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && !strb.push && !strb.clear) |=> (count == $past(count) - CW'(1)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !statusRead) |=> overrun);

  assert_overrun_read_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !pushValid) |=> !overrun);

  assert_disabled_write_keeps_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrite && !ctlData[0] && !pushValid && !popReq) |=> (count == $past(count)));

  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrite && ctlData[0] && ctlData[1]) |=> !dataReady);

  assert_break_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && pushBrk && (count == '0) && !popReq) |=> (rdData == 8'h00 && headBrk));

  assert_empty_pop_ignored_R12: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !dataReady && !pushValid && !ctlWrite) |=> !dataReady);
endmodule

bind rxq_top rxq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushBrk(pushBrk),
  .popReq(popReq), .ctlWrite(ctlWrite), .ctlData(ctlData),
  .statusRead(statusRead), .count(count), .strb(strb), .rdData(rdData),
  .dataReady(dataReady), .overrun(overrun), .headBrk(headBrk)
);

// File: tb/rxq_top_test.sv
module rxq_top_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 0, pushParErr = 0, pushFrmErr = 0, pushBrk = 0;
  logic popReq = 0, statusRead = 0, ctlWrite = 0;
  logic [7:0] pushData = '0, ctlData = '0;
  logic [7:0] rdData;
  logic dataReady, overrun, trigHit, headParErr, headFrmErr, headBrk, errInQueue;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rxq_top uut (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
    .pushParErr(pushParErr), .pushFrmErr(pushFrmErr), .pushBrk(pushBrk),
    .popReq(popReq), .statusRead(statusRead), .ctlWrite(ctlWrite),
    .ctlData(ctlData), .rdData(rdData), .dataReady(dataReady),
    .overrun(overrun), .trigHit(trigHit), .headParErr(headParErr),
    .headFrmErr(headFrmErr), .headBrk(headBrk), .errInQueue(errInQueue)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic pe = 0, input logic fe = 0, input logic bi = 0);
    pushValid = 1; pushData = d; pushParErr = pe; pushFrmErr = fe; pushBrk = bi;
    @(negedge clk);
    pushValid = 0; pushParErr = 0; pushFrmErr = 0; pushBrk = 0;
  endtask

  task automatic pop();
    popReq = 1; @(negedge clk); popReq = 0;
  endtask

  task automatic readStatus();
    statusRead = 1; @(negedge clk); statusRead = 0;
  endtask

  task automatic ctl(input logic [7:0] v);
    ctlWrite = 1; ctlData = v; @(negedge clk); ctlWrite = 0; ctlData = '0;
  endtask

  task automatic t_reset();
    chk("R1", "dataReady", dataReady, 0);
    chk("R1", "overrun", overrun, 0);
    chk("R1", "trigHit", trigHit, 0);
    chk("R1", "errInQueue", errInQueue, 0);
    chk("R1", "headFlags", {headParErr, headFrmErr, headBrk}, 0);
    chk("R2", "rdData empty", rdData, 0);
  endtask

  task automatic t_order();
    ctl(8'h01);
    pop();  // empty read
    chk("R12", "dataReady after empty pop", dataReady, 0);
    push(8'hA1); push(8'hB2); push(8'hC3);
    chk("R2", "dataReady", dataReady, 1);
    chk("R2", "head1", rdData, 8'hA1);
    pop(); chk("R2", "head2", rdData, 8'hB2);
    pop(); chk("R2", "head3", rdData, 8'hC3);
    pop(); chk("R2", "dataReady drained", dataReady, 0);
    chk("R12", "no overrun", overrun, 0);
  endtask

  task automatic t_full();
    ctl(8'h03);
    for (int i = 0; i < 16; i++) push(8'(i * 3 + 1));
    chk("R3", "no overrun at 16", overrun, 0);
    push(8'hEE);
    chk("R3", "overrun on 17th", overrun, 1);
    @(negedge clk);
    chk("R4", "overrun sticky", overrun, 1);
    for (int i = 0; i < 16; i++) begin
      chk("R3", "kept order", rdData, i * 3 + 1);
      pop();
    end
    chk("R3", "dropped byte absent", dataReady, 0);
    chk("R4", "still set before read", overrun, 1);
    readStatus();
    chk("R4", "cleared by status read", overrun, 0);
  endtask

  task automatic t_disabled();
    ctl(8'h03);
    ctl(8'h00);
    push(8'h5A);
    chk("R5", "single held", overrun, 0);
    push(8'h6B);
    chk("R5", "second overruns", overrun, 1);
    chk("R5", "first kept", rdData, 8'h5A);
    readStatus();
    pop();
    chk("R5", "empty after pop", dataReady, 0);
  endtask

  task automatic t_ignored();
    ctl(8'hC3);
    push(8'h11); push(8'h22);
    chk("R6", "trig 14 not hit", trigHit, 0);
    ctl(8'hC2);
    chk("R6", "not cleared", dataReady, 1);
    chk("R6", "head kept", rdData, 8'h11);
    ctl(8'h81);  // enable again, threshold 8
    chk("R8", "2 < 8", trigHit, 0);
    pop(); pop();
    chk("R6", "drained", dataReady, 0);
  endtask

  task automatic t_clear();
    ctl(8'h01);
    push(8'h31); push(8'h32, 1); push(8'h33);
    chk("R10", "err queued", errInQueue, 1);
    ctl(8'h03);
    chk("R7", "cleared", dataReady, 0);
    chk("R7", "err gone", errInQueue, 0);
    ctl(8'h01);
    push(8'h44);
    ctl(8'h01);
    chk("R7", "one-shot", dataReady, 1);
    chk("R7", "head after clear", rdData, 8'h44);
    ctl(8'h03);
    readStatus();
  endtask

  task automatic t_trigger();
    int lv[4] = '{1, 4, 8, 14};
    for (int s = 0; s < 4; s++) begin
      ctl(8'((s << 6) | 3));
      chk("R8", "empty no trig", trigHit, 0);
      for (int n = 1; n <= 15; n++) begin
        push(8'(n));
        chk("R8", $sformatf("sel%0d n%0d", s, n), trigHit, (n >= lv[s]) ? 1 : 0);
      end
    end
    ctl(8'h03);
  endtask

  task automatic t_errors();
    ctl(8'h03);
    readStatus();
    push(8'h01);
    push(8'h02, 1, 0, 0);
    push(8'h55, 0, 0, 1);
    push(8'h04, 0, 1, 0);
    push(8'h05);
    chk("R9", "clean head flags", {headParErr, headFrmErr, headBrk}, 0);
    chk("R10", "errInQueue", errInQueue, 1);
    pop();
    chk("R9", "parity at head", headParErr, 1);
    chk("R9", "no brk yet", headBrk, 0);
    pop();
    chk("R11", "break stored as zero", rdData, 0);
    chk("R9", "brk at head", headBrk, 1);
    chk("R9", "parity sticky", headParErr, 1);
    readStatus();
    chk("R9", "read clears", {headParErr, headFrmErr, headBrk}, 0);
    pop();
    chk("R9", "framing at head", headFrmErr, 1);
    chk("R10", "still err", errInQueue, 1);
    pop();
    chk("R10", "only clean left", errInQueue, 0);
    chk("R9", "framing sticky", headFrmErr, 1);
    chk("R2", "last head", rdData, 8'h05);
    readStatus();
    chk("R9", "cleared again", headFrmErr, 0);
    pop();
    chk("R2", "empty", dataReady, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_full();
    t_disabled();
    t_ignored();
    t_clear();
    t_trigger();
    t_errors();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule